// File: doc/BRIEF.md
# Host Port Halfword Access Controller

This block is the slave side of a 16-bit host port. An external host reads or writes a 32-bit internal word by issuing two halfword strobes in a row. The first strobe carries the upper half and the second carries the lower half. The block merges the chip select and the two data strobes into one internal strobe. It samples the host's access type, read/write flag and halfword flag, either on an optional address strobe or on the start of the internal strobe. It turns each pair of halfwords into a single request on a simple request/acknowledge memory port.

All host pins are asynchronous to the block clock. They pass through a two-stage synchronizer, and edges are detected in the clock domain before anything is captured. A read fetches the whole word on the first halfword. The lower half is buffered so the second halfword needs no second request. A write is held back until the second halfword's strobe ends. An active-low ready output tells the host when read data is valid and when the port is busy. An active-low interrupt pin follows a core-controlled bit that is clear after reset.

Top module: `hp_halfword_ctrl`

## Requirements
- R1: A transfer starts only while chip select and both data strobes are all low. Pulsing the data strobes with chip select high, or with only one data strobe low, issues no memory request, leaves `proto_err` at 0 and leaves `host_dout` unchanged.
- R2: While `host_as_n` is used, access type, `host_rnw` and `host_hsel` are taken at its falling edge. Later changes to these inputs, before or during the strobe, have no effect on the transfer.
- R3: With `host_as_n` held high, the same control inputs are taken when the internal strobe starts. Changes after that have no effect.
- R4: `host_hsel`=0 selects bits [31:16] and `host_hsel`=1 selects bits [15:0]. Exactly one write request is made for a write pair, after the second strobe ends. It carries `{first, second}` and the access type of the pair.
- R5: `host_be_n` is active low, with bit 1 for the high byte of the halfword. `mem_be[3:2]` comes from the first halfword and `mem_be[1:0]` from the second, both active high.
- R6: A read with `host_hsel`=0 makes one read request and holds `host_rdy_n` high until `mem_ack`. It then drives `mem_rdata[31:15+1]` on `host_dout`.
- R7: A read with `host_hsel`=1 that follows a first-half read returns the buffered `mem_rdata[15:0]` without a new request.
- R8: A second halfword with no first halfword pending, or with a different access type or `host_rnw`, sets the sticky `proto_err`. It discards the stored first half, makes no request and leaves `host_dout` unchanged.
- R9: `host_irq_n` is high from reset. It goes low the cycle after `core_irq_set` and high the cycle after `core_irq_clr`; set wins over clear.
- R10: `mem_req` stays high with stable `mem_we`, `mem_kind` and `mem_wdata` until `mem_ack`. `host_rdy_n` is high whenever a request is outstanding and low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_ds1_n | input | 1 | Host data strobe 1, active low |
| host_ds2_n | input | 1 | Host data strobe 2, active low |
| host_as_n | input | 1 | Optional address strobe, active low, tie high if unused |
| host_kind | input | KW | Access type field |
| host_rnw | input | 1 | 1 = read, 0 = write |
| host_hsel | input | 1 | 0 = first (upper) halfword, 1 = second (lower) |
| host_be_n | input | HW/8 | Byte enables, active low |
| host_din | input | HW | Write data from host |
| host_dout | output | HW | Read data to host |
| host_rdy_n | output | 1 | Ready, low when data valid / port free |
| host_irq_n | output | 1 | Interrupt to host, active low |
| core_irq_set | input | 1 | Sets the interrupt bit |
| core_irq_clr | input | 1 | Clears the interrupt bit |
| mem_req | output | 1 | Internal memory request |
| mem_we | output | 1 | Request is a write |
| mem_kind | output | KW | Access type of the request |
| mem_wdata | output | 2*HW | Write word |
| mem_be | output | HW/4 | Write byte enables, active high |
| mem_ack | input | 1 | One-cycle acknowledge |
| mem_rdata | input | 2*HW | Read word, valid with `mem_ack` |
| proto_err | output | 1 | Sticky halfword protocol error |

## Verification
Word writes and reads are applied both with the address strobe in use and with it tied high. In each case the control inputs are scrambled after their capture point, which separates the two capture paths from a design that samples control late. A write with a sparse byte-enable pattern followed by a read-back separates the halfword order and the byte-lane mapping. A lone second halfword and a pair with mismatched access type separate error handling from a design that issues a request anyway. Strobe patterns missing one qualifier show whether the strobe merge really requires all three signals.

// File: rtl/hp_halfword_ctrl.sv
module hp_halfword_ctrl #(
  parameter int HW = 16,
  parameter int KW = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_cs_n,
  input  logic               host_ds1_n,
  input  logic               host_ds2_n,
  input  logic               host_as_n,
  input  logic [KW-1:0]      host_kind,
  input  logic               host_rnw,
  input  logic               host_hsel,
  input  logic [HW/8-1:0]    host_be_n,
  input  logic [HW-1:0]      host_din,
  output logic [HW-1:0]      host_dout,
  output logic               host_rdy_n,
  output logic               host_irq_n,
  input  logic               core_irq_set,
  input  logic               core_irq_clr,
  output logic               mem_req,
  output logic               mem_we,
  output logic [KW-1:0]      mem_kind,
  output logic [2*HW-1:0]    mem_wdata,
  output logic [HW/4-1:0]    mem_be,
  input  logic               mem_ack,
  input  logic [2*HW-1:0]    mem_rdata,
  output logic               proto_err
);
  localparam int BW = HW/8;
  localparam int WW = 2*HW;
  localparam int NS = 4 + KW + 2 + BW + HW;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_ACT, S_FLUSH} st_t;

  logic [NS-1:0] sy1, sy2;
  logic cs_s, ds1_s, ds2_s, as_s, rnw_s, hsel_s;
  logic [KW-1:0] kind_s;
  logic [BW-1:0] ben_s;
  logic [HW-1:0] din_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '1;
      sy2 <= '1;
    end else begin
      sy1 <= {host_cs_n, host_ds1_n, host_ds2_n, host_as_n, host_kind,
              host_rnw, host_hsel, host_be_n, host_din};
      sy2 <= sy1;
    end

  assign {cs_s, ds1_s, ds2_s, as_s, kind_s, rnw_s, hsel_s, ben_s, din_s} = sy2;

  logic stb, stb_q, as_q;
  assign stb = ~cs_s & ~ds1_s & ~ds2_s;

  logic stb_fall, stb_rise, as_fall;
  assign stb_fall = stb & ~stb_q;
  assign stb_rise = ~stb & stb_q;
  assign as_fall  = as_q & ~as_s;

  logic [KW-1:0] c_kind;
  logic c_rnw, c_hsel, as_armed;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stb_q    <= 1'b0;
      as_q     <= 1'b1;
      c_kind   <= '0;
      c_rnw    <= 1'b0;
      c_hsel   <= 1'b0;
      as_armed <= 1'b0;
    end else begin
      stb_q <= stb;
      as_q  <= as_s;
      if (as_fall || (stb_fall && !as_armed)) begin
        c_kind <= kind_s;
        c_rnw  <= rnw_s;
        c_hsel <= hsel_s;
      end
      if (as_fall)       as_armed <= 1'b1;
      else if (stb_rise) as_armed <= 1'b0;
    end

  st_t state;
  logic have_first, f_rnw;
  logic [KW-1:0] f_kind;
  logic [HW-1:0] up_w, lo_buf;
  logic [BW-1:0] be_hi;
  logic mismatch;

  assign mismatch = c_hsel & (~have_first | (c_kind != f_kind) | (c_rnw != f_rnw));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state      <= S_IDLE;
      have_first <= 1'b0;
      f_kind     <= '0;
      f_rnw      <= 1'b0;
      up_w       <= '0;
      be_hi      <= '0;
      lo_buf     <= '0;
      host_dout  <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_kind   <= '0;
      mem_wdata  <= '0;
      mem_be     <= '0;
      proto_err  <= 1'b0;
    end else begin
      case (state)
        S_IDLE:
          if (stb && stb_q) begin
            state <= S_ACT;
            if (!c_hsel) begin
              have_first <= 1'b1;
              f_kind     <= c_kind;
              f_rnw      <= c_rnw;
              if (c_rnw) begin
                mem_req  <= 1'b1;
                mem_we   <= 1'b0;
                mem_kind <= c_kind;
                state    <= S_FETCH;
              end
            end else if (mismatch) begin
              proto_err  <= 1'b1;
              have_first <= 1'b0;
            end else if (c_rnw) begin
              host_dout  <= lo_buf;
              have_first <= 1'b0;
            end
          end
        S_FETCH:
          if (mem_ack) begin
            mem_req   <= 1'b0;
            host_dout <= mem_rdata[WW-1:HW];
            lo_buf    <= mem_rdata[HW-1:0];
            state     <= S_ACT;
          end
        S_ACT:
          if (!stb) begin
            state <= S_IDLE;
            if (!c_rnw) begin
              if (!c_hsel) begin
                up_w  <= din_s;
                be_hi <= ~ben_s;
              end else if (have_first) begin
                mem_req    <= 1'b1;
                mem_we     <= 1'b1;
                mem_kind   <= c_kind;
                mem_wdata  <= {up_w, din_s};
                mem_be     <= {be_hi, ~ben_s};
                have_first <= 1'b0;
                state      <= S_FLUSH;
              end
            end
          end
        S_FLUSH:
          if (mem_ack) begin
            mem_req <= 1'b0;
            state   <= S_IDLE;
          end
        default: state <= S_IDLE;
      endcase
    end

  assign host_rdy_n = (state == S_FETCH) || (state == S_FLUSH);

  logic irq_bit;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            irq_bit <= 1'b0;
    else if (core_irq_set) irq_bit <= 1'b1;
    else if (core_irq_clr) irq_bit <= 1'b0;

  assign host_irq_n = ~irq_bit;

  p_rdy_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> host_rdy_n);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_kind) && $stable(mem_wdata));

  p_wr_after_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) && mem_we |-> !stb);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  p_irq_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    core_irq_set |=> !host_irq_n);

  p_irq_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    core_irq_clr && !core_irq_set |=> host_irq_n);

endmodule

// File: tb/test_hp_halfword_ctrl.sv
module test_hp_halfword_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic host_cs_n = 1, host_ds1_n = 1, host_ds2_n = 1, host_as_n = 1;
  logic [1:0] host_kind = 0;
  logic host_rnw = 0, host_hsel = 0;
  logic [1:0] host_be_n = 2'b11;
  logic [15:0] host_din = 0;
  logic [15:0] host_dout;
  logic host_rdy_n, host_irq_n;
  logic core_irq_set = 0, core_irq_clr = 0;
  logic mem_req, mem_we;
  logic [1:0] mem_kind;
  logic [31:0] mem_wdata;
  logic [3:0] mem_be;
  logic mem_ack = 0;
  logic [31:0] mem_rdata = 0;
  logic proto_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  hp_halfword_ctrl i_hp_halfword_ctrl (
    .clk(clk), .rst_n(rst_n),
    .host_cs_n(host_cs_n), .host_ds1_n(host_ds1_n), .host_ds2_n(host_ds2_n),
    .host_as_n(host_as_n), .host_kind(host_kind), .host_rnw(host_rnw),
    .host_hsel(host_hsel), .host_be_n(host_be_n), .host_din(host_din),
    .host_dout(host_dout), .host_rdy_n(host_rdy_n), .host_irq_n(host_irq_n),
    .core_irq_set(core_irq_set), .core_irq_clr(core_irq_clr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_kind(mem_kind),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .proto_err(proto_err));

  int vectors = 0, fails = 0;
  int n_rd = 0, n_wr = 0, cnt = 0;
  logic [31:0] last_wdata = 0;
  logic [3:0] last_be = 0;
  logic [1:0] last_kind = 0;
  logic [31:0] bmem [4];
  logic [31:0] exp_mem [4];
  logic m_irq;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 0; cnt = 0;
      for (int i = 0; i < 4; i++) bmem[i] = 0;
    end else if (mem_ack) begin
      mem_ack = 0; cnt = 0;
    end else if (mem_req) begin
      cnt++;
      if (cnt == 2) begin
        mem_ack = 1;
        if (mem_we) begin
          bmem[mem_kind] = merge(bmem[mem_kind], mem_wdata, mem_be);
          last_wdata = mem_wdata; last_be = mem_be; last_kind = mem_kind;
          n_wr++;
        end else begin
          mem_rdata = bmem[mem_kind];
          n_rd++;
        end
      end
    end
  end

  always @(posedge clk)
    if (!rst_n) m_irq <= 0;
    else if (core_irq_set) m_irq <= 1;
    else if (core_irq_clr) m_irq <= 0;

  always @(negedge clk)
    if (rst_n) chk("R9 per-clock interrupt pin", {31'b0, host_irq_n}, {31'b0, ~m_irq});

  task automatic wait_rdy;
    for (int i = 0; i < 200 && host_rdy_n; i++) @(negedge clk);
  endtask

  task automatic hacc(input bit use_as, input logic [1:0] kind, input bit rnw, input bit hsel,
                      input logic [15:0] wd, input logic [1:0] ben, output logic [15:0] rd);
    @(negedge clk);
    host_kind = kind; host_rnw = rnw; host_hsel = hsel; host_din = wd; host_be_n = ben;
    if (use_as) begin
      host_as_n = 0;
      repeat (3) @(negedge clk);
      host_kind = ~kind; host_rnw = ~rnw; host_hsel = ~hsel;
      host_as_n = 1;
    end
    host_cs_n = 0; host_ds1_n = 0; host_ds2_n = 0;
    repeat (6) @(negedge clk);
    if (!use_as) begin
      host_kind = ~kind; host_rnw = ~rnw; host_hsel = ~hsel;
    end
    wait_rdy();
    rd = host_dout;
    host_cs_n = 1; host_ds1_n = 1; host_ds2_n = 1;
    repeat (6) @(negedge clk);
    wait_rdy();
    repeat (2) @(negedge clk);
  endtask

  task automatic wr32(input bit use_as, input logic [1:0] kind, input logic [31:0] d,
                      input logic [3:0] be, input string tag);
    logic [15:0] dummy;
    int w0 = n_wr;
    hacc(use_as, kind, 0, 0, d[31:16], ~be[3:2], dummy);
    chk({tag, " R4 no request after first half"}, n_wr, w0);
    hacc(use_as, kind, 0, 1, d[15:0], ~be[1:0], dummy);
    chk({tag, " R4 one request after pair"}, n_wr, w0 + 1);
    chk({tag, " R4 write word order"}, last_wdata, d);
    chk({tag, " R5 byte enables"}, {28'b0, last_be}, {28'b0, be});
    chk({tag, " R4 access type"}, {30'b0, last_kind}, {30'b0, kind});
    exp_mem[kind] = merge(exp_mem[kind], d, be);
  endtask

  task automatic rd32(input bit use_as, input logic [1:0] kind, input string tag);
    logic [15:0] hi, lo;
    int r0 = n_rd;
    hacc(use_as, kind, 1, 0, 16'h0, 2'b11, hi);
    chk({tag, " R6 one fetch on first half"}, n_rd, r0 + 1);
    chk({tag, " R6 upper half"}, {16'b0, hi}, {16'b0, exp_mem[kind][31:16]});
    hacc(use_as, kind, 1, 1, 16'h0, 2'b11, lo);
    chk({tag, " R7 no fetch on second half"}, n_rd, r0 + 1);
    chk({tag, " R7 lower half"}, {16'b0, lo}, {16'b0, exp_mem[kind][15:0]});
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] rd, dprev;
    int r0, w0;
    for (int i = 0; i < 4; i++) exp_mem[i] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset ready low", {31'b0, host_rdy_n}, 0);
    chk("R9 reset irq high", {31'b0, host_irq_n}, 1);
    chk("R10 reset no request", {31'b0, mem_req}, 0);
    chk("R8 reset no error", {31'b0, proto_err}, 0);

    r0 = n_rd; w0 = n_wr; dprev = host_dout;
    host_rnw = 1; host_hsel = 0;
    host_ds1_n = 0; host_ds2_n = 0;
    repeat (12) @(negedge clk);
    host_ds1_n = 1; host_ds2_n = 1;
    repeat (4) @(negedge clk);
    host_cs_n = 0; host_ds1_n = 0;
    repeat (12) @(negedge clk);
    host_cs_n = 1; host_ds1_n = 1;
    repeat (6) @(negedge clk);
    chk("R1 no request without full strobe", n_rd + n_wr, r0 + w0);
    chk("R1 no error", {31'b0, proto_err}, 0);
    chk("R1 dout unchanged", {16'b0, host_dout}, {16'b0, dprev});

    wr32(0, 2'd1, 32'hA5A5_1234, 4'hF, "R3 strobe capture");
    rd32(0, 2'd1, "R3 strobe capture");
    wr32(1, 2'd2, 32'hDEAD_BEEF, 4'hF, "R2 address strobe");
    rd32(1, 2'd2, "R2 address strobe");
    wr32(0, 2'd1, 32'h1122_3344, 4'b1010, "R5 sparse lanes");
    rd32(0, 2'd1, "R5 sparse lanes");
    chk("R5 merged word", exp_mem[1], 32'h11A5_3334);

    w0 = n_wr;
    hacc(0, 2'd3, 0, 0, 16'h5555, 2'b00, rd);
    hacc(0, 2'd0, 0, 1, 16'h6666, 2'b00, rd);
    chk("R8 mismatch sets error", {31'b0, proto_err}, 1);
    chk("R8 mismatch no request", n_wr, w0);

    r0 = n_rd; dprev = host_dout;
    hacc(1, 2'd2, 1, 1, 16'h0, 2'b11, rd);
    chk("R8 lone second no request", n_rd, r0);
    chk("R8 lone second dout unchanged", {16'b0, host_dout}, {16'b0, dprev});
    chk("R8 error sticky", {31'b0, proto_err}, 1);

    wr32(1, 2'd3, 32'h0BAD_F00D, 4'hF, "R4 after error");
    rd32(0, 2'd3, "R6 after error");

    @(negedge clk) core_irq_set = 1;
    @(negedge clk) core_irq_set = 0;
    chk("R9 irq asserted", {31'b0, host_irq_n}, 0);
    repeat (3) @(negedge clk);
    core_irq_set = 1; core_irq_clr = 1;
    @(negedge clk) core_irq_set = 0;
    chk("R9 set wins", {31'b0, host_irq_n}, 0);
    @(negedge clk) core_irq_clr = 0;
    chk("R9 irq cleared", {31'b0, host_irq_n}, 1);
    repeat (4) @(negedge clk);
    summary();
  end
endmodule